// File: doc/BRIEF.md
# Double-Buffered Receive FIFO Read Port

This block is the bus-facing read side of a multi-pipe receive packet buffer. Every pipe owns two packet planes. A load side writes a whole packet into a free plane of a chosen pipe, together with its byte length. A bus reader drains the plane of the currently selected pipe in 8-, 16- or 32-bit units. When one plane is used up, the port moves to the other plane of that pipe.

A small control register picks the current pipe, the access width, the lane order for multi-byte reads and how the received-length counter behaves. In the hold mode the counter shows the plane's packet length until the plane is drained. In the count-down mode it shows the bytes still to be read. A self-clearing rewind bit restarts reading of the current plane from its first byte. A ready flag tells the reader whether the current plane has unread data.

Top module: `rxfifo_rdport`

## Requirements
- R1: After reset the control register reads 0, `rdy` is 0 and `dtln` is 0.
- R2: Control register layout: pipe in [3:0], access width in [5:4] (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit), big-endian select in [6], count-down mode in [7], rewind in [8]. The rewind bit and bits [15:9] always read 0. A write takes effect on the next cycle.
- R3: A load with `wr_pipe` below NPIPE and a length from 1 to PLANE_BYTES stores byte k from `wr_data[8k+7:8k]` into a free plane of that pipe. A load is ignored when both planes of the pipe are occupied, when the length is 0 or too large, or when the pipe number is out of range.
- R4: A read (`rd_en` while `rdy` is 1) consumes 1, 2 or 4 bytes according to the width. In little-endian order the byte at the read pointer appears in `rd_data[7:0]`. Lanes above the width are 0, as are bytes past the packet length. `rd_en` while `rdy` is 0 changes nothing, and `rd_data` is 0 then.
- R5: With big-endian select the byte at the read pointer appears in the most significant lane of the access width, and the following bytes appear in the lower lanes.
- R6: In hold mode `dtln` equals the current plane's packet length and does not change while the plane is being read.
- R7: The read that reaches or passes the packet length frees the plane. The port then moves to the other plane, which becomes current with its own length, or `rdy` drops to 0 if that plane is empty. Planes are read in load order.
- R8: In count-down mode `dtln` equals the packet length minus the bytes already read, and it falls by the access byte count on each read.
- R9: `rdy` is 1 exactly when the current pipe number is below NPIPE, the pipe is marked receive in `pipe_is_tx`, and its current plane holds a packet. `dtln` is 0 whenever `rdy` is 0.
- R10: A control write with rewind = 1, a pipe field equal to the current pipe and `rdy` = 1 sets the read pointer of the current plane back to its first byte. If a read happens in the same cycle, the rewind wins and no bytes are consumed.
- R11: A rewind is ignored when the same write changes the pipe field, when `rdy` is 0, or when the pipe is marked transmit.
- R12: Each pipe keeps its own planes and read pointer across changes of the current pipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write value |
| ctl_rdata | output | 16 | Control register read value |
| pipe_is_tx | input | NPIPE | Per-pipe direction, 1 = transmit |
| wr_en | input | 1 | Load one packet into a plane |
| wr_pipe | input | 4 | Pipe that receives the packet |
| wr_len | input | LEN_W | Packet length in bytes |
| wr_data | input | 8*PLANE_BYTES | Packet bytes, byte k in bits [8k+7:8k] |
| rd_en | input | 1 | Read strobe from the bus |
| rd_data | output | 32 | Read data for the current access |
| rdy | output | 1 | Current plane holds unread data |
| dtln | output | LEN_W | Received-length counter |

## Verification
The bench builds the port with NPIPE = 3 and PLANE_BYTES = 6. With three pipes, a 4-bit pipe field can point past the last pipe, so the out-of-range select and load cases can be reached. A 6-byte plane is not a multiple of the 32-bit access. As a result, the last wide read of a full plane runs past the packet end, which exercises the zero-filled lanes, the overshooting drain and the count-down step near its floor in both lane orders.

// File: rtl/rxfp_pkg.sv
package rxfp_pkg;

  typedef enum logic [1:0] {
    AW_8   = 2'd0,
    AW_16  = 2'd1,
    AW_32  = 2'd2,
    AW_32B = 2'd3
  } acc_width_e;

  // Control fields, most significant first: [7] count-down, [6] big-endian,
  // [5:4] access width, [3:0] current pipe.
  typedef struct packed {
    logic       cnt_dec;
    logic       big_end;
    acc_width_e width;
    logic [3:0] pipe;
  } ctl_t;

  localparam int CTL_REWIND_BIT = 8;

  function automatic logic [2:0] width_bytes(acc_width_e w);
    case (w)
      AW_8:    return 3'd1;
      AW_16:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/rxfp_ctl.sv
module rxfp_ctl
  import rxfp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  input  logic        cur_rdy,
  output ctl_t        ctl,
  output logic        rewind_fire,
  output logic [15:0] rdata
);

  ctl_t ctl_q;
  ctl_t wr_fields;
  logic ctl_unused;

  always_comb begin
    wr_fields = ctl_t'(wdata[7:0]);
    // rewind only when the pipe field is unchanged and the plane is readable
    rewind_fire = we && wdata[CTL_REWIND_BIT] && (wr_fields.pipe == ctl_q.pipe) && cur_rdy;
  end

  assign ctl_unused = ^wdata[15:9];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (we) begin
      ctl_q <= wr_fields;
    end
  end

  assign ctl   = ctl_q;
  assign rdata = {8'h00, ctl_q};

  // R2: a write is visible on the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[7:0] == $past(wdata[7:0])));

endmodule

// File: rtl/rxfp_pipe.sv
module rxfp_pipe #(
  parameter  int PLANE_BYTES = 8,
  parameter  int LEN_W       = 4,
  localparam int DATA_W      = PLANE_BYTES * 8,
  localparam int SUM_W       = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  load_len,
  input  logic [DATA_W-1:0] load_data,
  input  logic              take,
  input  logic [2:0]        take_bytes,
  input  logic              rewind,
  output logic              cur_full,
  output logic [LEN_W-1:0]  cur_len,
  output logic [LEN_W-1:0]  cur_ptr,
  output logic [DATA_W-1:0] cur_data
);

  logic [1:0]        full_q, full_d;
  logic              rsel_q, rsel_d;
  logic [LEN_W-1:0]  ptr_q, ptr_d;
  logic [LEN_W-1:0]  len_q  [2];
  logic [DATA_W-1:0] data_q [2];
  logic              fill_sel, accept, drain;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    fill_sel = full_q[rsel_q] ? ~rsel_q : rsel_q;
    accept   = load && !full_q[fill_sel];
    sum      = {1'b0, ptr_q} + SUM_W'(take_bytes);
    drain    = take && !rewind && (sum >= {1'b0, len_q[rsel_q]});

    ptr_d = ptr_q;
    if (rewind || drain) ptr_d = '0;
    else if (take)       ptr_d = sum[LEN_W-1:0];

    rsel_d = drain ? ~rsel_q : rsel_q;

    full_d = full_q;
    if (drain)  full_d[rsel_q]   = 1'b0;
    if (accept) full_d[fill_sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      rsel_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      full_q <= full_d;
      rsel_q <= rsel_d;
      ptr_q  <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      len_q[fill_sel]  <= load_len;
      data_q[fill_sel] <= load_data;
    end
  end

  assign cur_full = full_q[rsel_q];
  assign cur_len  = len_q[rsel_q];
  assign cur_ptr  = ptr_q;
  assign cur_data = data_q[rsel_q];

  // R7: a loaded plane never has its pointer at or past its length
  a_r7_ptr_in_plane: assert property (@(posedge clk) disable iff (!rst_n)
    cur_full |-> (cur_ptr < cur_len));

  // R6: a read that does not finish the plane leaves the plane length alone
  a_r6_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rewind && (sum < {1'b0, cur_len})) |=> $stable(cur_len));

  // R10: rewind restarts the same plane at byte 0
  a_r10_rewind_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (cur_full && (cur_ptr == '0)));

endmodule

// File: rtl/rxfp_lane.sv
module rxfp_lane
  import rxfp_pkg::*;
#(
  parameter  int PLANE_BYTES = 8,
  parameter  int LEN_W       = 4,
  localparam int DATA_W      = PLANE_BYTES * 8,
  localparam int SW          = LEN_W + 1
) (
  input  logic [DATA_W-1:0] plane,
  input  logic [LEN_W-1:0]  len,
  input  logic [LEN_W-1:0]  ptr,
  input  acc_width_e        width,
  input  logic              big_end,
  output logic [31:0]       lanes
);

  typedef logic [SW-1:0] idx_t;

  logic [2:0] nb;
  idx_t       src;

  always_comb begin
    nb    = width_bytes(width);
    lanes = '0;
    src   = '0;
    for (int j = 0; j < 4; j++) begin
      if (3'(j) < nb) begin
        if (big_end) src = {1'b0, ptr} + idx_t'(nb) - idx_t'(j + 1);
        else         src = {1'b0, ptr} + idx_t'(j);
        for (int k = 0; k < PLANE_BYTES; k++) begin
          if ((src == idx_t'(k)) && (idx_t'(k) < {1'b0, len}))
            lanes[j*8 +: 8] = plane[k*8 +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/rxfifo_rdport.sv
module rxfifo_rdport
  import rxfp_pkg::*;
#(
  parameter  int NPIPE       = 4,
  parameter  int PLANE_BYTES = 8,
  localparam int LEN_W       = $clog2(PLANE_BYTES + 1),
  localparam int DATA_W      = PLANE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [15:0]       ctl_wdata,
  output logic [15:0]       ctl_rdata,
  input  logic [NPIPE-1:0]  pipe_is_tx,
  input  logic              wr_en,
  input  logic [3:0]        wr_pipe,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              rdy,
  output logic [LEN_W-1:0]  dtln
);

  ctl_t              ctl;
  logic              rewind_fire;
  logic [2:0]        nb;
  logic              wr_ok;
  logic              p_full [NPIPE];
  logic [LEN_W-1:0]  p_len  [NPIPE];
  logic [LEN_W-1:0]  p_ptr  [NPIPE];
  logic [DATA_W-1:0] p_data [NPIPE];
  logic              cur_full, cur_tx;
  logic [LEN_W-1:0]  cur_len, cur_ptr;
  logic [DATA_W-1:0] cur_data;
  logic [31:0]       lane_out;

  rxfp_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (ctl_we),
    .wdata       (ctl_wdata),
    .cur_rdy     (rdy),
    .ctl         (ctl),
    .rewind_fire (rewind_fire),
    .rdata       (ctl_rdata)
  );

  assign nb    = width_bytes(ctl.width);
  assign wr_ok = wr_en && (wr_len != '0) && (wr_len <= LEN_W'(PLANE_BYTES));

  for (genvar g = 0; g < NPIPE; g++) begin : g_pipe
    rxfp_pipe #(.PLANE_BYTES(PLANE_BYTES), .LEN_W(LEN_W)) u_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (wr_ok && (wr_pipe == 4'(g))),
      .load_len   (wr_len),
      .load_data  (wr_data),
      .take       (rd_en && rdy && (ctl.pipe == 4'(g))),
      .take_bytes (nb),
      .rewind     (rewind_fire && (ctl.pipe == 4'(g))),
      .cur_full   (p_full[g]),
      .cur_len    (p_len[g]),
      .cur_ptr    (p_ptr[g]),
      .cur_data   (p_data[g])
    );
  end

  always_comb begin
    cur_full = 1'b0;
    cur_tx   = 1'b0;
    cur_len  = '0;
    cur_ptr  = '0;
    cur_data = '0;
    for (int i = 0; i < NPIPE; i++) begin
      if (ctl.pipe == 4'(i)) begin
        cur_full = p_full[i];
        cur_tx   = pipe_is_tx[i];
        cur_len  = p_len[i];
        cur_ptr  = p_ptr[i];
        cur_data = p_data[i];
      end
    end
  end

  rxfp_lane #(.PLANE_BYTES(PLANE_BYTES), .LEN_W(LEN_W)) u_lane (
    .plane   (cur_data),
    .len     (cur_len),
    .ptr     (cur_ptr),
    .width   (ctl.width),
    .big_end (ctl.big_end),
    .lanes   (lane_out)
  );

  assign rdy     = cur_full && !cur_tx;
  assign rd_data = rdy ? lane_out : 32'h0;
  assign dtln    = !rdy ? '0 : (ctl.cnt_dec ? (cur_len - cur_ptr) : cur_len);

  // R9: a readable plane always reports a nonzero length
  a_r9_ready_has_len: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (dtln != '0));

  // R8: count-down steps by the access size on a read that leaves data behind
  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rdy && ctl.cnt_dec && !ctl_we && (dtln > LEN_W'(nb)))
      |=> ((pipe_is_tx != $past(pipe_is_tx)) || (dtln == $past(dtln) - LEN_W'($past(nb)))));

endmodule

// File: tb/rxfifo_rdport_test.sv
module rxfifo_rdport_test;
  localparam int NP = 3;
  localparam int PB = 6;
  localparam int LW = 3;
  localparam int DW = PB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [15:0]   ctl_wdata = '0;
  logic [15:0]   ctl_rdata;
  logic [NP-1:0] pipe_is_tx = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_pipe = '0;
  logic [LW-1:0] wr_len = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [31:0]   rd_data;
  logic          rdy;
  logic [LW-1:0] dtln;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  rxfifo_rdport #(.NPIPE(NP), .PLANE_BYTES(PB)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .pipe_is_tx(pipe_is_tx), .wr_en(wr_en),
    .wr_pipe(wr_pipe), .wr_len(wr_len), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rdy(rdy), .dtln(dtln)
  );

  // behavioural reference: per pipe up to two packets in arrival order
  logic [7:0]    m_ctl;
  int            m_c [NP];
  int            m_p [NP];
  int            m_l [NP][2];
  logic [DW-1:0] m_d [NP][2];

  function automatic int m_nb();
    case (m_ctl[5:4])
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  function automatic bit m_rdy();
    int p;
    p = int'(m_ctl[3:0]);
    if (p >= NP) return 1'b0;
    if (pipe_is_tx[p]) return 1'b0;
    return m_c[p] > 0;
  endfunction

  function automatic int m_dtln();
    int p;
    p = int'(m_ctl[3:0]);
    if (!m_rdy()) return 0;
    return m_ctl[7] ? m_l[p][0] - m_p[p] : m_l[p][0];
  endfunction

  function automatic logic [31:0] m_rd();
    int p, nb, idx;
    logic [31:0] v;
    v = '0;
    if (!m_rdy()) return v;
    p  = int'(m_ctl[3:0]);
    nb = m_nb();
    for (int j = 0; j < nb; j++) begin
      idx = m_ctl[6] ? m_p[p] + nb - 1 - j : m_p[p] + j;
      if (idx < m_l[p][0]) v[j*8 +: 8] = m_d[p][0][idx*8 +: 8];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    int p, nb, wp;
    bit r0, rew, acc;
    if (!rst_n) begin
      m_ctl = '0;
      for (int i = 0; i < NP; i++) begin m_c[i] = 0; m_p[i] = 0; end
    end else begin
      p   = int'(m_ctl[3:0]);
      r0  = m_rdy();
      nb  = m_nb();
      rew = ctl_we && ctl_wdata[8] && (ctl_wdata[3:0] == m_ctl[3:0]) && r0;
      wp  = int'(wr_pipe);
      acc = wr_en && (wp < NP) && (wr_len != 0) && (int'(wr_len) <= PB);
      if (acc) acc = m_c[wp] < 2;
      if (rew) m_p[p] = 0;
      else if (rd_en && r0) begin
        m_p[p] = m_p[p] + nb;
        if (m_p[p] >= m_l[p][0]) begin
          m_l[p][0] = m_l[p][1];
          m_d[p][0] = m_d[p][1];
          m_c[p]    = m_c[p] - 1;
          m_p[p]    = 0;
        end
      end
      if (acc) begin
        m_l[wp][m_c[wp]] = int'(wr_len);
        m_d[wp][m_c[wp]] = wr_data;
        m_c[wp] = m_c[wp] + 1;
      end
      if (ctl_we) m_ctl = ctl_wdata[7:0];
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9", "rdy", 32'(rdy), 32'(m_rdy()));
      chk(m_ctl[7] ? "R8" : "R6", "dtln", 32'(dtln), 32'(m_dtln()));
      chk(m_ctl[6] ? "R5" : "R4", "rd_data", rd_data, m_rd());
      chk("R2", "ctl_rdata", 32'(ctl_rdata), {24'h0, m_ctl});
    end
  end

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ctl_write(int pipe, int w, bit big, bit mode, bit rew);
    ctl_we    = 1'b1;
    ctl_wdata = {7'd0, rew, mode, big, 2'(w), 4'(pipe)};
    tick();
    ctl_we = 1'b0;
  endtask

  function automatic logic [DW-1:0] mk(int base);
    logic [DW-1:0] d;
    for (int k = 0; k < PB; k++) d[k*8 +: 8] = 8'(base + k);
    return d;
  endfunction

  task automatic load(int pipe, int len, int base);
    wr_en   = 1'b1;
    wr_pipe = 4'(pipe);
    wr_len  = LW'(len);
    wr_data = mk(base);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(int n);
    rd_en = 1'b1;
    repeat (n) tick();
    rd_en = 1'b0;
  endtask

  task automatic look();
    @(negedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    look();
    chk("R1", "ctl_rdata", 32'(ctl_rdata), 0);
    chk("R1", "rdy", 32'(rdy), 0);
    chk("R1", "dtln", 32'(dtln), 0);

    // hold mode, double buffering on pipe 0
    ctl_write(0, 0, 0, 0, 0);
    load(0, 5, 8'h11);
    look(); chk("R3", "dtln", 32'(dtln), 5);
    rd(2);
    look(); chk("R6", "dtln held", 32'(dtln), 5);
    load(0, 3, 8'h21);
    load(0, 4, 8'h41);               // both planes busy: dropped
    rd(3);
    look(); chk("R7", "next plane len", 32'(dtln), 3);
    chk("R7", "next plane byte", rd_data, 32'h21);

    // count-down, 16-bit little-endian
    ctl_write(0, 1, 0, 1, 0);
    look(); chk("R4", "16b data", rd_data, 32'h2221);
    rd(1);
    look(); chk("R8", "dtln down", 32'(dtln), 1);
    chk("R4", "past end zero", rd_data, 32'h0023);
    rd(1);
    look(); chk("R3", "third load dropped", 32'(rdy), 0);

    // big-endian 32-bit on pipe 1
    load(1, 6, 8'hA0);
    ctl_write(1, 2, 1, 1, 0);
    look(); chk("R5", "big 32b", rd_data, 32'hA0A1A2A3);
    rd(1);
    look(); chk("R5", "big tail", rd_data, 32'hA4A50000);
    chk("R8", "dtln", 32'(dtln), 2);

    ctl_write(1, 2, 1, 1, 1);
    look(); chk("R10", "rewind data", rd_data, 32'hA0A1A2A3);
    chk("R10", "rewind dtln", 32'(dtln), 6);
    chk("R2", "rewind reads 0", 32'(ctl_rdata), 32'h00E1);

    rd(1);
    ctl_write(0, 2, 1, 1, 1);        // pipe change with rewind
    ctl_write(1, 2, 1, 1, 0);
    look(); chk("R11", "rewind with pipe change", 32'(dtln), 2);
    chk("R12", "pipe 1 kept pointer", rd_data, 32'hA4A50000);

    pipe_is_tx[1] = 1'b1;
    tick();
    look(); chk("R9", "tx not ready", 32'(rdy), 0);
    ctl_write(1, 2, 1, 1, 1);
    pipe_is_tx[1] = 1'b0;
    tick();
    look(); chk("R11", "tx rewind ignored", 32'(dtln), 2);

    // rewind and read in the same cycle
    ctl_we = 1'b1; ctl_wdata = {7'd0, 1'b1, 1'b1, 1'b1, 2'd2, 4'd1};
    rd_en = 1'b1;
    tick();
    ctl_we = 1'b0; rd_en = 1'b0;
    look(); chk("R10", "rewind beats read", 32'(dtln), 6);
    rd(2);
    look(); chk("R7", "drained", 32'(rdy), 0);

    // out-of-range pipe
    load(7, 3, 8'h55);
    ctl_write(5, 0, 0, 0, 0);
    look(); chk("R9", "unmapped pipe", 32'(rdy), 0);
    chk("R4", "unmapped data", rd_data, 0);

    // width code 3 behaves as 32-bit
    load(2, 4, 8'h31);
    ctl_write(2, 3, 0, 0, 0);
    look(); chk("R4", "code 3 width", rd_data, 32'h34333231);
    rd(1);
    look(); chk("R7", "pipe 2 drained", 32'(rdy), 0);

    // mixed traffic, checked each cycle against the reference
    for (int it = 0; it < 3000; it++) begin
      ctl_we    = ($urandom_range(0, 5) == 0);
      ctl_wdata = {7'd0, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255))};
      ctl_wdata[3:0] = 4'($urandom_range(0, 3));
      wr_en   = ($urandom_range(0, 2) == 0);
      wr_pipe = 4'($urandom_range(0, 3));
      wr_len  = LW'($urandom_range(0, 7));
      wr_data = mk($urandom_range(0, 255));
      rd_en   = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 15) == 0) pipe_is_tx = NP'($urandom_range(0, 7));
      tick();
    end
    ctl_we = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    look();
    summary();
  end

endmodule